// File: doc/BRIEF.md
# Upper-Memory Bank Switch Controller

This block sits beside an 8-bit CPU bus and manages the top 12K of its 64K address space (0xD000–0xFFFF) when a 16K RAM expansion card is fitted. Reading any of sixteen switch addresses in the range 0xC080–0xC08F sets three pieces of state. The first is whether reads of the upper region come from card RAM or from ROM. The second is whether stores there reach card RAM or are thrown away. The third is which of two 4K card banks backs 0xD000–0xDFFF.

The block works from its current state, with no clock delay, to produce the read-source selects and a gated card write enable. It also produces the translated card-RAM and ROM addresses for every upper-region access. Accesses below 0xD000 are passed out unchanged and flagged as not handled here. The memory arrays are outside the block.

Top module: `lcx_bank_ctrl`

## Requirements
- R1: A switch access is a cycle with `cpu_rd`=1, `card_present`=1 and `cpu_addr[15:4]`=0xC08. It loads the configuration at the next rising clock edge. Address bit 2 is ignored, so 0xC084–0xC087 act like 0xC080–0xC083 and 0xC08C–0xC08F act like 0xC088–0xC08B. A store (`cpu_wr`=1, `cpu_rd`=0) to a switch address changes nothing.
- R2: Switch address bit 3 = 0 selects the second bank (`bank2_sel`=1). Bit 3 = 1 selects the first bank (`bank2_sel`=0).
- R3: Switch address bits [1:0] set the mode. 00 gives RAM read and no write. 01 gives ROM read and RAM write. 10 gives ROM read and no write. 11 gives RAM read and RAM write. `rd_ram_mode`=1 for 00 and 11, and `wr_enabled`=1 for 01 and 11.
- R4: For an address in 0xD000–0xDFFF, `card_addr` = {1'b0, `bank2_sel`, `cpu_addr[11:0]`}. For 0xE000–0xFFFF, `card_addr` = `cpu_addr` − 0xC000 (0x2000–0x3FFF), whichever bank is selected.
- R5: For any address at or above 0xD000, `rom_addr` = `cpu_addr` − 0xD000 (0x0000–0x2FFF).
- R6: For an address at or above 0xD000, `sel_card_rd` = `rd_ram_mode` and `sel_rom_rd` = !`rd_ram_mode`.
- R7: `card_wr_en` = 1 only when `cpu_wr`=1, the address is at or above 0xD000 and `wr_enabled`=1. Any other store to the upper region is discarded. No output ever writes ROM.
- R8: With `card_present`=0, switch reads leave all configuration unchanged.
- R9: After reset the configuration is ROM read, writes disabled, first bank (`rd_ram_mode`=0, `wr_enabled`=0, `bank2_sel`=0).
- R10: For an address below 0xD000, `not_mine`=1 and `low_addr`=`cpu_addr`. In that case `sel_card_rd`, `sel_rom_rd` and `card_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| card_present | input | 1 | Expansion RAM fitted |
| sel_card_rd | output | 1 | Read upper region from card RAM |
| sel_rom_rd | output | 1 | Read upper region from ROM |
| card_wr_en | output | 1 | Store goes to card RAM |
| rd_ram_mode | output | 1 | Configured read source is card RAM |
| wr_enabled | output | 1 | Configured write permission |
| bank2_sel | output | 1 | Second 4K bank selected |
| card_addr | output | 14 | Mapped card-RAM address |
| rom_addr | output | 14 | Mapped ROM address |
| low_addr | output | 16 | Pass-through address |
| not_mine | output | 1 | Access below the upper region |

## Verification
The configuration outputs change one rising edge after a switch read. The selects, enables and mapped addresses follow the address and the current state with no register in between. The bench therefore drives each switch read on a falling edge and lets one rising edge pass. It then presents a probe address and samples the combinational outputs shortly after that falling edge, well away from the next rising edge. Reset release passes through a two-stage synchronizer, so the bench waits three edges before its first access.

// File: rtl/lcx_pkg.sv
package lcx_pkg;

  typedef struct packed {
    logic rd_ram;   // reads of upper region from card RAM
    logic wr_en;    // stores reach card RAM
    logic bank2;    // second 4K bank for the D page
  } lcx_cfg_t;

  localparam lcx_cfg_t LCX_CFG_RST = '{rd_ram: 1'b0, wr_en: 1'b0, bank2: 1'b0};

  // sel = {addr[3], addr[1:0]}
  function automatic lcx_cfg_t lcx_decode(input logic [2:0] sel);
    lcx_cfg_t c;
    c.bank2  = ~sel[2];
    c.rd_ram = ~(sel[1] ^ sel[0]);
    c.wr_en  = sel[0];
    return c;
  endfunction

endpackage

// File: rtl/lcx_rst_sync.sv
module lcx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lcx_switch_reg.sv
module lcx_switch_reg
  import lcx_pkg::*;
#(
  parameter int          PAGE_W  = 12,
  parameter logic [11:0] SW_PAGE = 12'hC08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] addr_page,
  input  logic [2:0]        addr_sel,
  input  logic              cpu_rd,
  input  logic              card_present,
  output lcx_cfg_t          cfg
);
  logic     sw_hit;
  lcx_cfg_t cfg_d, cfg_q;

  assign sw_hit = cpu_rd && card_present && (addr_page == SW_PAGE[PAGE_W-1:0]);

  always_comb begin
    cfg_d = cfg_q;
    if (sw_hit) cfg_d = lcx_decode(addr_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= LCX_CFG_RST;
    else if (sw_hit) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lcx_addr_map.sv
module lcx_addr_map
  import lcx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CARD_AW = 14,
  parameter int ROM_AW  = 14
) (
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_wr,
  input  lcx_cfg_t           cfg,
  output logic               sel_card_rd,
  output logic               sel_rom_rd,
  output logic               card_wr_en,
  output logic [CARD_AW-1:0] card_addr,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [ADDR_W-1:0]  low_addr,
  output logic               not_mine
);
  localparam int          PG_LSB   = ADDR_W - 4;
  localparam logic [3:0]  HI_PAGE  = 4'hD;
  localparam logic [ROM_AW-1:0] ROM_OFS = ROM_AW'(12'h000) | (ROM_AW'(1) << PG_LSB);

  logic [3:0] page4;
  logic       hi;

  assign page4 = cpu_addr[ADDR_W-1:PG_LSB];
  assign hi    = (page4 >= HI_PAGE);

  always_comb begin
    card_addr = '0;
    rom_addr  = '0;
    if (hi) begin
      if (page4 == HI_PAGE)
        card_addr = {1'b0, cfg.bank2, cpu_addr[PG_LSB-1:0]};
      else
        card_addr = cpu_addr[CARD_AW-1:0];
      rom_addr = cpu_addr[ROM_AW-1:0] - ROM_OFS;
    end
  end

  assign sel_card_rd = hi &&  cfg.rd_ram;
  assign sel_rom_rd  = hi && !cfg.rd_ram;
  assign card_wr_en  = hi && cpu_wr && cfg.wr_en;
  assign low_addr    = cpu_addr;
  assign not_mine    = !hi;
endmodule

// File: rtl/lcx_bank_ctrl.sv
module lcx_bank_ctrl
  import lcx_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CARD_AW = 14,
  parameter int ROM_AW  = 14,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic               card_present,
  output logic               sel_card_rd,
  output logic               sel_rom_rd,
  output logic               card_wr_en,
  output logic               rd_ram_mode,
  output logic               wr_enabled,
  output logic               bank2_sel,
  output logic [CARD_AW-1:0] card_addr,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic [ADDR_W-1:0]  low_addr,
  output logic               not_mine
);
  localparam int PAGE_W = ADDR_W - 4;

  logic     rst_sync_n;
  lcx_cfg_t cfg;

  lcx_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lcx_switch_reg #(.PAGE_W(PAGE_W)) u_sw (
    .clk(clk), .rst_n(rst_sync_n),
    .addr_page(cpu_addr[ADDR_W-1:4]),
    .addr_sel({cpu_addr[3], cpu_addr[1:0]}),
    .cpu_rd(cpu_rd), .card_present(card_present), .cfg(cfg)
  );

  lcx_addr_map #(.ADDR_W(ADDR_W), .CARD_AW(CARD_AW), .ROM_AW(ROM_AW)) u_map (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cfg(cfg),
    .sel_card_rd(sel_card_rd), .sel_rom_rd(sel_rom_rd), .card_wr_en(card_wr_en),
    .card_addr(card_addr), .rom_addr(rom_addr), .low_addr(low_addr), .not_mine(not_mine)
  );

  assign rd_ram_mode = cfg.rd_ram;
  assign wr_enabled  = cfg.wr_en;
  assign bank2_sel   = cfg.bank2;
endmodule

// File: rtl/lcx_bank_ctrl_chk.sv
module lcx_bank_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        card_present,
  input logic        sel_card_rd,
  input logic        sel_rom_rd,
  input logic        card_wr_en,
  input logic        rd_ram_mode,
  input logic        wr_enabled,
  input logic        bank2_sel,
  input logic [13:0] card_addr,
  input logic [13:0] rom_addr,
  input logic [15:0] low_addr,
  input logic        not_mine
);
  logic sw_acc;
  assign sw_acc = cpu_rd && card_present && (cpu_addr[15:4] == 12'hC08);

  assert_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> (bank2_sel == !$past(cpu_addr[3])));

  assert_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_acc |=> (wr_enabled == $past(cpu_addr[0])) &&
               (rd_ram_mode == ($past(cpu_addr[1]) == $past(cpu_addr[0]))));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_acc |=> $stable(bank2_sel) && $stable(wr_enabled) && $stable(rd_ram_mode));

  assert_nocard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |=> $stable(bank2_sel) && $stable(wr_enabled) && $stable(rd_ram_mode));

  assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_wr_en |-> (wr_enabled && cpu_wr && !not_mine));

  assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'hD000) |-> (not_mine && low_addr == cpu_addr &&
                               !sel_card_rd && !sel_rom_rd && !card_wr_en));

  assert_upper8k_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (card_addr[13] && card_addr[12:0] == cpu_addr[12:0]));

  assert_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hD000) |-> (rom_addr == 14'(cpu_addr - 16'hD000)));

  assert_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hD000) |-> (sel_card_rd != sel_rom_rd));
endmodule

bind lcx_bank_ctrl lcx_bank_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .card_present(card_present), .sel_card_rd(sel_card_rd),
  .sel_rom_rd(sel_rom_rd), .card_wr_en(card_wr_en), .rd_ram_mode(rd_ram_mode),
  .wr_enabled(wr_enabled), .bank2_sel(bank2_sel), .card_addr(card_addr),
  .rom_addr(rom_addr), .low_addr(low_addr), .not_mine(not_mine)
);

// File: tb/lcx_bank_ctrl_tb.sv
module lcx_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, card_present = 1'b1;
  logic        sel_card_rd, sel_rom_rd, card_wr_en, rd_ram_mode, wr_enabled, bank2_sel, not_mine;
  logic [13:0] card_addr, rom_addr;
  logic [15:0] low_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcx_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .card_present(card_present), .sel_card_rd(sel_card_rd), .sel_rom_rd(sel_rom_rd),
    .card_wr_en(card_wr_en), .rd_ram_mode(rd_ram_mode), .wr_enabled(wr_enabled),
    .bank2_sel(bank2_sel), .card_addr(card_addr), .rom_addr(rom_addr),
    .low_addr(low_addr), .not_mine(not_mine)
  );

  // {switch nibble, probe address, {rd_ram, wr_en, bank2}, expected card address}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'h0, 16'hD123, 3'b101, 14'h1123},
    {4'h8, 16'hD123, 3'b100, 14'h0123},
    {4'h1, 16'hD456, 3'b011, 14'h1456},
    {4'h9, 16'hDFFF, 3'b010, 14'h0FFF},
    {4'h2, 16'hE000, 3'b001, 14'h2000},
    {4'hB, 16'hF00F, 3'b110, 14'h300F},
    {4'h3, 16'hFFFF, 3'b111, 14'h3FFF},
    {4'hA, 16'hD000, 3'b000, 14'h0000},
    {4'h7, 16'hD800, 3'b111, 14'h1800},
    {4'hC, 16'hE800, 3'b100, 14'h2800}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sw_read(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic check_cfg(input string tag, input logic [2:0] exp);
    #1;
    check(tag, {29'd0, rd_ram_mode, wr_enabled, bank2_sel}, {29'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    cpu_addr = 16'hD000;
    check_cfg("R9 reset cfg", 3'b000);
    check("R9 rom read after reset", {31'd0, sel_rom_rd}, 32'd1);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] pa;
      logic [2:0]  em;
      pa = VEC[i][32:17];
      em = VEC[i][16:14];
      sw_read({12'hC08, VEC[i][36:33]});
      cpu_addr = pa; cpu_wr = 1'b1;
      check_cfg("R1/R2/R3 cfg", em);
      check("R4 card_addr", {18'd0, card_addr}, {18'd0, VEC[i][13:0]});
      check("R5 rom_addr", {18'd0, rom_addr}, {16'd0, pa - 16'hD000} & 32'h3FFF);
      check("R6 sel_card_rd", {31'd0, sel_card_rd}, {31'd0, em[2]});
      check("R6 sel_rom_rd", {31'd0, sel_rom_rd}, {31'd0, !em[2]});
      check("R7 card_wr_en", {31'd0, card_wr_en}, {31'd0, em[1]});
      cpu_wr = 1'b0;
    end

    // R7 write disabled discards, read-enabled write absent
    sw_read(16'hC080);
    cpu_addr = 16'hF000; cpu_wr = 1'b1; #1;
    check("R7 discard store", {31'd0, card_wr_en}, 32'd0);
    cpu_wr = 1'b0;

    // R8 no card: switch read ignored (cfg currently 101)
    card_present = 1'b0;
    sw_read(16'hC08B);
    check_cfg("R8 no card hold", 3'b101);
    card_present = 1'b1;

    // R1 store to a switch address ignored
    @(negedge clk);
    cpu_addr = 16'hC08B; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    check_cfg("R1 store ignored", 3'b101);

    // R1 read outside switch page ignored
    sw_read(16'hC09B);
    check_cfg("R1 other page ignored", 3'b101);

    // R10 below the upper region
    sw_read(16'hC08B);
    cpu_addr = 16'h1234; cpu_wr = 1'b1; #1;
    check("R10 not_mine", {31'd0, not_mine}, 32'd1);
    check("R10 low_addr", {16'd0, low_addr}, 32'h1234);
    check("R10 no selects", {29'd0, sel_card_rd, sel_rom_rd, card_wr_en}, 32'd0);
    @(negedge clk);
    cpu_addr = 16'hCFFF; #1;
    check("R10 boundary CFFF", {28'd0, not_mine, sel_card_rd, sel_rom_rd, card_wr_en}, 32'h8);
    cpu_wr = 1'b0;

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_cfg("R9 async reset", 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_cfg("R9 after release", 3'b000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule